// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate Unit

This block is a signed multiply-accumulate datapath for 16-bit Q.15 operands. Each clock cycle it forms the 32-bit two's complement product of two operands. According to a 2-bit opcode, it then keeps, loads, adds the product to, or subtracts the product from a 40-bit accumulator. The eight accumulator bits above the product width act as guard bits, so long sums can run without wrapping.

A registered fractional-mode bit doubles the product in the same cycle as the multiply. With the bit set, the product becomes a Q.31 value; with it clear, the product stays Q.30. Three read paths run from the accumulator at all times:
- the raw 40-bit value;
- a 16-bit Q.15 word, cut from the high half of the Q.31 alignment, with a flag that reports when the guard bits do not fit in that word;
- a 32-bit word rescaled by a variable arithmetic right shift, which returns Qm.n products to their operand format.

Two registered flags report signed and unsigned wrap-around of the most recent add or subtract.

Top module: `fxmac_q15`

## Requirements
- R1: On a clock edge with `rst` high, the accumulator, the fractional-mode bit and both overflow flags become 0.
- R2: Opcode 00 (hold) leaves the accumulator unchanged.
- R3: Opcode 01 (load) writes the sign-extended signed product `opa*opb` into the accumulator. When fractional mode is off, this is the Q.30 alignment.
- R4: With fractional mode on, the product is shifted left by one bit in the same cycle before it is used, giving Q.31. The mode that applies is the value registered before the edge.
- R5: Opcode 10 (add) adds the aligned product to the accumulator, modulo 2^40.
- R6: Opcode 11 (subtract) subtracts the aligned product from the accumulator, modulo 2^40.
- R7: `ovf_signed` is set after an add or subtract whose 40-bit signed result left the range from -2^39 to 2^39-1. After a hold or a load it is 0.
- R8: `ovf_unsigned` is set after an add that carried out of bit 39, or after a subtract that borrowed (the accumulator, read as unsigned, was below the product). After a hold or a load it is 0.
- R9: `q15_out` is accumulator bits [31:16] when fractional mode is on and bits [30:15] when it is off. The discarded low bits are truncated.
- R10: `q15_range_err` is 1 when the accumulator bits above `q15_out`, together with its sign bit, are not all equal. These are bits [39:31] in fractional mode and bits [39:30] otherwise.
- R11: `shr_out` is the low 32 bits of the accumulator shifted arithmetically right by `shamt` (0 to 31), with the sign bit copied into the vacated positions.
- R12: A high `mode_we` loads `mode_frac` into the fractional-mode bit at the clock edge. Otherwise the bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Write strobe for the fractional-mode bit |
| mode_frac | input | 1 | New value of the fractional-mode bit |
| op | input | 2 | 00 hold, 01 load, 10 add, 11 subtract |
| opa | input | 16 | Signed Q.15 multiplicand |
| opb | input | 16 | Signed Q.15 multiplier |
| shamt | input | 5 | Arithmetic right-shift amount for `shr_out` |
| acc_out | output | 40 | Accumulator value |
| q15_out | output | 16 | Truncated Q.15 readout |
| q15_range_err | output | 1 | Guard bits do not fit the Q.15 readout |
| shr_out | output | 32 | Rescaled readout |
| ovf_signed | output | 1 | Signed wrap on the last add or subtract |
| ovf_unsigned | output | 1 | Carry or borrow on the last add or subtract |

## Verification
The hardest state to reach is a wrap of the full 40-bit accumulator, because the guard bits hold 256 maximum-size products. The stimulus turns on fractional mode and loads (-1)*(-1), which doubles to +2^31. It then issues 255 more adds of the same product, so the sum reaches 2^39 and raises the signed flag exactly on the last add. Along the way the same product also checks the out-of-range flag: +1.0 does not fit a Q.15 word, so the flag is set after the very first load. Borrow and carry cases follow from subtracting a positive product from zero and from adding a negative product to a positive sum.

// File: rtl/fxmac_q15.sv
module fxmac_q15 #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int SHW  = 5,
  parameter int OUTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_we,
  input  logic            mode_frac,
  input  logic [1:0]      op,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic [SHW-1:0]  shamt,
  output logic [ACCW-1:0] acc_out,
  output logic [OPW-1:0]  q15_out,
  output logic            q15_range_err,
  output logic [OUTW-1:0] shr_out,
  output logic            ovf_signed,
  output logic            ovf_unsigned
);
  localparam int PW = 2 * OPW;
  localparam int GF = ACCW - PW + 1;
  localparam int GI = ACCW - PW + 2;

  localparam logic [1:0] OP_HOLD = 2'b00;
  localparam logic [1:0] OP_LOAD = 2'b01;
  localparam logic [1:0] OP_ADD  = 2'b10;
  localparam logic [1:0] OP_SUB  = 2'b11;

  logic signed [ACCW-1:0] acc;
  logic                   frac_on;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] pext, padj;
  logic [ACCW:0]          sum, dif;
  logic [GF-1:0]          gfrac;
  logic [GI-1:0]          gint;

  assign prod = $signed(opa) * $signed(opb);
  assign pext = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign padj = frac_on ? (pext <<< 1) : pext;
  assign sum  = {1'b0, acc} + {1'b0, padj};
  assign dif  = {1'b0, acc} - {1'b0, padj};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc          <= '0;
      frac_on      <= 1'b0;
      ovf_signed   <= 1'b0;
      ovf_unsigned <= 1'b0;
    end else begin
      if (mode_we) frac_on <= mode_frac;
      ovf_signed   <= 1'b0;
      ovf_unsigned <= 1'b0;
      case (op)
        OP_LOAD: acc <= padj;
        OP_ADD: begin
          acc          <= sum[ACCW-1:0];
          ovf_unsigned <= sum[ACCW];
          ovf_signed   <= (acc[ACCW-1] == padj[ACCW-1]) && (sum[ACCW-1] != acc[ACCW-1]);
        end
        OP_SUB: begin
          acc          <= dif[ACCW-1:0];
          ovf_unsigned <= dif[ACCW];
          ovf_signed   <= (acc[ACCW-1] != padj[ACCW-1]) && (dif[ACCW-1] != acc[ACCW-1]);
        end
        default: acc <= acc;
      endcase
    end
  end

  assign gfrac         = acc[ACCW-1:PW-1];
  assign gint          = acc[ACCW-1:PW-2];
  assign acc_out       = acc;
  assign q15_out       = frac_on ? acc[PW-1 -: OPW] : acc[PW-2 -: OPW];
  assign q15_range_err = frac_on ? !((&gfrac) || !(|gfrac)) : !((&gint) || !(|gint));
  assign shr_out       = OUTW'(acc >>> shamt);

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> acc == $past(acc));
  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && !frac_on) |=> acc == $signed($past(opa)) * $signed($past(opb)));
  // R4
  a_r4_frac_load: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && frac_on) |=> (acc[0] == 1'b0 && (acc >>> 1) == $signed($past(opa)) * $signed($past(opb))));
  // R5
  a_r5_add: assert property (@(posedge clk) disable iff (rst)
    op == OP_ADD |=> acc == $past(acc) + $past(padj));
  // R7 and R8
  a_r7_quiet_flags: assert property (@(posedge clk) disable iff (rst)
    op[1] == 1'b0 |=> (!ovf_signed && !ovf_unsigned));
  // R12
  a_r12_mode_keep: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> frac_on == $past(frac_on));
endmodule

// File: tb/sim_fxmac_q15.sv
`timescale 1ns/1ps
module sim_fxmac_q15;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 1'b0, mode_frac = 1'b0;
  logic [1:0] op = 2'b00;
  logic [15:0] opa = '0, opb = '0;
  logic [4:0] shamt = '0;
  logic [39:0] acc_out;
  logic [15:0] q15_out;
  logic q15_range_err, ovf_signed, ovf_unsigned;
  logic [31:0] shr_out;

  fxmac_q15 u0 (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_frac(mode_frac), .op(op),
    .opa(opa), .opb(opb), .shamt(shamt), .acc_out(acc_out), .q15_out(q15_out),
    .q15_range_err(q15_range_err), .shr_out(shr_out),
    .ovf_signed(ovf_signed), .ovf_unsigned(ovf_unsigned));

  always #2 clk = ~clk;

  typedef struct packed {
    logic [39:0] acc;
    logic [15:0] q;
    logic        rng;
    logic [31:0] sh;
    logic        os;
    logic        ou;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic signed [39:0] m_acc = '0;
  logic m_frac = 1'b0;

  function automatic exp_t expect_now(input logic os, input logic ou, input logic [4:0] sh);
    exp_t e;
    logic [8:0] g9;
    logic [9:0] g10;
    g9  = m_acc[39:31];
    g10 = m_acc[39:30];
    e.acc = m_acc;
    e.q   = m_frac ? m_acc[31:16] : m_acc[30:15];
    e.rng = m_frac ? !(g9 == '0 || g9 == '1) : !(g10 == '0 || g10 == '1);
    e.sh  = 32'(m_acc >>> sh);
    e.os  = os;
    e.ou  = ou;
    return e;
  endfunction

  task automatic step(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                      input logic mwe, input logic md, input logic [4:0] sh, input string tag);
    logic signed [39:0] p;
    logic signed [40:0] s41;
    logic os, ou;
    @(negedge clk);
    op = o; opa = a; opb = b; mode_we = mwe; mode_frac = md; shamt = sh;
    p = $signed(a) * $signed(b);
    if (m_frac) p = p * 2;
    os = 1'b0; ou = 1'b0;
    case (o)
      2'b01: m_acc = p;
      2'b10: begin
        s41 = {m_acc[39], m_acc} + {p[39], p};
        os = s41[40] != s41[39];
        ou = ({1'b0, m_acc} + {1'b0, p}) > 41'h0FF_FFFF_FFFF;
        m_acc = s41[39:0];
      end
      2'b11: begin
        s41 = {m_acc[39], m_acc} - {p[39], p};
        os = s41[40] != s41[39];
        ou = $unsigned(m_acc) < $unsigned(p);
        m_acc = s41[39:0];
      end
      default: ;
    endcase
    if (mwe) m_frac = md;
    exp_q.push_back(expect_now(os, ou, sh));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      exp_t got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = '{acc: acc_out, q: q15_out, rng: q15_range_err, sh: shr_out,
              os: ovf_signed, ou: ovf_unsigned};
      n_cmp++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: acc=%h q=%h rng=%b sh=%h os=%b ou=%b expected acc=%h q=%h rng=%b sh=%h os=%b ou=%b",
                 t, got.acc, got.q, got.rng, got.sh, got.os, got.ou,
                 e.acc, e.q, e.rng, e.sh, e.os, e.ou);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: hold reset over a few edges with nonzero stimulus present
    op = 2'b10; opa = 16'h7FFF; opb = 16'h7FFF; mode_we = 1'b1; mode_frac = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (acc_out !== '0 || ovf_signed !== 1'b0 || ovf_unsigned !== 1'b0 || q15_out !== '0) begin
      n_bad++;
      $display("FAIL R1: acc=%h os=%b ou=%b q=%h expected all zero", acc_out, ovf_signed, ovf_unsigned, q15_out);
    end
    op = 2'b00; mode_we = 1'b0; mode_frac = 1'b0;
    rst = 1'b0;

    step(2'b00, 16'h1234, 16'h4321, 0, 0, 5'd0, "R1 R2");      // frac stays off after reset, hold
    step(2'b01, 16'h4000, 16'h4000, 0, 0, 5'd0, "R3 R9");      // 0.5*0.5 Q.30
    step(2'b00, 16'h7FFF, 16'h8000, 0, 0, 5'd4, "R2 R11");
    step(2'b10, 16'hC000, 16'h2000, 0, 0, 5'd15, "R5 R11");    // add negative
    step(2'b11, 16'h1111, 16'h0123, 0, 0, 5'd31, "R6 R11");
    step(2'b01, 16'h8000, 16'h7FFF, 0, 0, 5'd15, "R3 R11");    // negative product
    step(2'b00, 16'h0, 16'h0, 0, 1, 5'd0, "R12");              // no strobe: mode unchanged
    step(2'b01, 16'h2000, 16'h4000, 0, 0, 5'd0, "R12 R3");     // still Q.30 alignment
    step(2'b01, 16'h2000, 16'h4000, 1, 1, 5'd0, "R4 R12");     // old mode applies in strobe cycle
    step(2'b01, 16'h2000, 16'h4000, 0, 0, 5'd0, "R4 R9");      // now doubled, Q.31 readout
    step(2'b10, 16'hF001, 16'h0FFF, 0, 0, 5'd7, "R4 R5");
    step(2'b11, 16'h7FFF, 16'h7FFF, 0, 0, 5'd1, "R6 R10");

    // R8: borrow from zero, then carry with negative product
    step(2'b01, 16'h0000, 16'h0000, 0, 0, 5'd0, "R3");
    step(2'b11, 16'h0100, 16'h0100, 0, 0, 5'd0, "R8 R6");
    step(2'b01, 16'h0100, 16'h0100, 0, 0, 5'd0, "R3");
    step(2'b10, 16'hFF00, 16'h0001, 0, 0, 5'd0, "R8 R5");

    // R10 and R7: -1 * -1 doubled is +1.0, then fill the guard bits
    step(2'b01, 16'h8000, 16'h8000, 0, 0, 5'd31, "R10 R4");
    for (int i = 0; i < 255; i++)
      step(2'b10, 16'h8000, 16'h8000, 0, 0, 5'd20, "R7 R5");
    step(2'b10, 16'h8000, 16'h8000, 0, 0, 5'd3, "R7 R8");
    step(2'b00, 16'h8000, 16'h8000, 0, 0, 5'd31, "R7 R11");
    step(2'b11, 16'h8000, 16'h8000, 0, 0, 5'd9, "R7 R6");

    // back to integer alignment, then readout with flag
    step(2'b00, 16'h0, 16'h0, 1, 0, 5'd0, "R12");
    step(2'b01, 16'h7FFF, 16'h7FFF, 0, 0, 5'd30, "R9 R10 R11");
    step(2'b10, 16'h7FFF, 16'h7FFF, 0, 0, 5'd0, "R10");
    step(2'b00, 16'h0, 16'h0, 0, 0, 5'd0, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule